// File: doc/BRIEF.md
# Cyclic bit interleaver for parallel sub-streams

The block sits after a bit demultiplexer and accepts up to six parallel bit sub-streams, one bit of each per accepted input beat. It gathers 126 beats into a block. It then emits 126 output words, one per output beat. In output word w, bit e is taken from sub-stream e of that block, read at a position that is cyclically shifted by an offset chosen for that sub-stream. Each sub-stream therefore gets its own rotation over the 126 positions.

A two-bit mode input selects two, four or six active sub-streams. The mode also selects which offsets apply to which sub-stream. A direction input either adds each offset or adds its complement modulo 126. The complement undoes the forward rotation, so the same block can act as interleaver or deinterleaver. Two block buffers alternate roles: one fills while the other drains. This allows one word per cycle in steady state, with a latency of one block. Both the input and the output use valid/ready handshakes.

Top module: `cyc_bit_ilv`

## Requirements
- R1: Each block holds exactly 126 input beats with positions w = 0..125. Its 126 output words leave in order of w, and each block's words leave before the next block's words.
- R2: With dir = 0 (forward), bit e of output word w equals bit e of the input beat at position (w + k_e) mod 126 of the same block.
- R3: Offsets by mode. For mode 0 (2 sub-streams), k_0..k_1 = 0, 63. For mode 1 (4 sub-streams), k_0..k_3 = 0, 63, 21, 84. For modes 2 and 3 (6 sub-streams), k_0..k_5 = 0, 63, 105, 42, 21, 84.
- R4: With dir = 1 (inverse), bit e of output word w equals bit e of the input beat at position (w + 126 − k_e) mod 126.
- R5: Output bits at or above the active sub-stream count are 0, and input bits at or above that count have no effect on the output.
- R6: mode and dir are sampled on the first accepted beat of each block and apply to the whole block. Changes during a block have no effect until the next block starts.
- R7: in_ready is low exactly when two completed blocks still hold unread words. No accepted beat is lost.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_word stays unchanged on the next cycle.
- R9: out_valid is high whenever a completed block has unread words. The first word of a block is therefore presented in the cycle after its 126th beat is accepted, and words can leave at one per cycle.
- R10: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Sub-stream count and offset set: 0 = two, 1 = four, 2 or 3 = six |
| dir | input | 1 | 0 = forward offsets, 1 = complemented offsets |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the beat |
| in_bits | input | 6 | One bit per sub-stream, sub-stream 0 in bit 0 |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 6 | Permuted bits, sub-stream 0 in bit 0 |

## Verification
The 126th accepted beat of a block is registered at a clock edge. From the next cycle, out_valid and the first word of that block are presented without any further delay. in_ready falls in the cycle after the edge that completes a second unread block, and rises in the cycle after the edge that takes the last word of the older one. The bench model applies each handshake at the same edge as the design. It then compares in_ready, out_valid and out_word at the following falling edge, so each result is checked in the very cycle it becomes due. Mode and direction are changed at random points inside blocks to exercise the sampling rule.

// File: rtl/cyc_bit_ilv.sv
module cyc_bit_ilv #(
  parameter int BLK = 126
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       dir,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [5:0] in_bits,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [5:0] out_word
);
  localparam int NS = 6;
  localparam int W  = $clog2(BLK);
  localparam logic [W-1:0] K1 = W'(BLK / 2);
  localparam logic [W-1:0] K2 = W'(BLK * 5 / 6);
  localparam logic [W-1:0] K3 = W'(BLK / 3);
  localparam logic [W-1:0] K4 = W'(BLK / 6);
  localparam logic [W-1:0] K5 = W'(BLK * 2 / 3);
  localparam logic [W:0]   BLKW = (W+1)'(BLK);

  function automatic logic [W-1:0] kof(input logic [1:0] m, input int e);
    logic [W-1:0] k;
    case (e)
      1: k = K1;
      2: k = (m == 2'd1) ? K4 : K2;
      3: k = (m == 2'd1) ? K5 : K3;
      4: k = K4;
      5: k = K5;
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic int nact(input logic [1:0] m);
    return (m == 2'd0) ? 2 : (m == 2'd1) ? 4 : 6;
  endfunction

  logic           wb, rb;
  logic [W-1:0]   wc, rc;
  logic [1:0]     full, fset, fclr;
  logic [1:0]     bm [2];
  logic           bd [2];
  logic [BLK-1:0] mem [2][NS];

  wire in_fire  = in_valid & in_ready;
  wire out_fire = out_valid & out_ready;
  wire wlast    = (wc == W'(BLK - 1));
  wire rlast    = (rc == W'(BLK - 1));

  assign in_ready  = ~full[wb];
  assign out_valid = full[rb];
  assign fset = (in_fire && wlast)   ? (2'b01 << wb) : 2'b00;
  assign fclr = (out_fire && rlast)  ? (2'b01 << rb) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb    <= 1'b0;
      rb    <= 1'b0;
      wc    <= '0;
      rc    <= '0;
      full  <= 2'b00;
      bm[0] <= 2'd0;
      bm[1] <= 2'd0;
      bd[0] <= 1'b0;
      bd[1] <= 1'b0;
    end else begin
      full <= (full | fset) & ~fclr;
      if (in_fire) begin
        if (wc == '0) begin
          bm[wb] <= mode;
          bd[wb] <= dir;
        end
        wc <= wlast ? '0 : wc + 1'b1;
        if (wlast) wb <= ~wb;
      end
      if (out_fire) begin
        rc <= rlast ? '0 : rc + 1'b1;
        if (rlast) rb <= ~rb;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire)
      for (int e = 0; e < NS; e++) mem[wb][e][wc] <= in_bits[e];
  end

  for (genvar g = 0; g < NS; g++) begin : g_lane
    logic [W-1:0] kv, ke, a;
    logic [W:0]   s;
    assign kv = kof(bm[rb], g);
    assign ke = (bd[rb] && kv != '0) ? W'(BLKW - {1'b0, kv}) : kv;
    assign s  = {1'b0, rc} + {1'b0, ke};
    assign a  = (s >= BLKW) ? W'(s - BLKW) : s[W-1:0];
    assign out_word[g] = (g < nact(bm[rb])) ? mem[rb][g][a] : 1'b0;
  end
endmodule

// File: rtl/cyc_bit_ilv_chk.sv
module cyc_bit_ilv_chk #(
  parameter int BLK = 126
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [5:0] out_word,
  input logic [1:0] rd_mode
);
  int occ;
  logic [5:0] mask;
  assign mask = (rd_mode == 2'd0) ? 6'b000011 : (rd_mode == 2'd1) ? 6'b001111 : 6'b111111;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 2 * BLK);
  a_r7_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> occ > BLK);
  a_r9_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ > 0);
  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word & ~mask) == 6'b0);
endmodule

bind cyc_bit_ilv cyc_bit_ilv_chk #(.BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .rd_mode(bm[rb])
);

// File: tb/cyc_bit_ilv_bench.sv
module cyc_bit_ilv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 126;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic dir = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [5:0] in_bits = 6'd0;
  logic in_ready, out_valid;
  logic [5:0] out_word;

  cyc_bit_ilv #(.BLK(BLK)) u_cyc_bit_ilv (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir(dir),
    .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [5:0] q[$];
  logic [5:0] cur [BLK];
  int cnt = 0;
  int bmode = 0, bdir = 0;

  function automatic int koff(int m, int e);
    int t2[2] = '{0, 63};
    int t4[4] = '{0, 63, 21, 84};
    int t6[6] = '{0, 63, 105, 42, 21, 84};
    if (m == 0) return t2[e];
    if (m == 1) return t4[e];
    return t6[e];
  endfunction

  function automatic int nact(int m);
    return (m == 0) ? 2 : (m == 1) ? 4 : 6;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic close_block();
    for (int w = 0; w < BLK; w++) begin
      logic [5:0] word = 6'd0;
      for (int e = 0; e < nact(bmode); e++) begin
        int k = koff(bmode, e);
        int idx = bdir ? (w + BLK - k) % BLK : (w + k) % BLK;
        word[e] = cur[idx][e];
      end
      q.push_back(word);
    end
  endtask

  task automatic step(bit iv, bit ordy);
    int pend;
    bit exp_rdy, exp_vld;
    @(negedge clk);
    pend = (q.size() + BLK - 1) / BLK;
    exp_rdy = (pend < 2);
    exp_vld = (q.size() > 0);
    chk(in_ready == exp_rdy, "R7 in_ready", int'(in_ready), int'(exp_rdy));
    chk(out_valid == exp_vld, "R9 out_valid", int'(out_valid), int'(exp_vld));
    // word checks cover R1 R2 R3 R4 R5 R6 (mode and dir latched at block start)
    if (exp_vld)
      chk(out_word == q[0], "R1 R2 R3 R4 R5 R6 out_word", int'(out_word), int'(q[0]));
    in_valid  = iv;
    out_ready = ordy;
    in_bits   = 6'($urandom);
    if (exp_vld && ordy) void'(q.pop_front());
    if (iv && exp_rdy) begin
      if (cnt == 0) begin bmode = int'(mode); bdir = int'(dir); end
      cur[cnt] = in_bits;
      cnt++;
      if (cnt == BLK) begin close_block(); cnt = 0; end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++) begin
        mode = 2'(m); dir = 1'(d);
        repeat (2 * BLK) step(1'b1, 1'b1);
      end
    repeat (BLK + 4) step(1'b0, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 40) == 0) begin mode = 2'($urandom); dir = 1'($urandom); end
      step(($urandom % 10) < 7, ($urandom % 10) < 6);
    end
    mode = 2'd2; dir = 1'b1;
    repeat (400) step(1'b1, 1'b0);
    chk(in_ready == 1'b0, "R7 stall when two blocks held", int'(in_ready), 0);
    repeat (600) step(1'b0, 1'b1);
    chk(out_valid == 1'b0, "R9 drained", int'(out_valid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule